// File: doc/BRIEF.md
# Packet address route decoder

This block sits behind one input of an 11-port packet switch. Port 0 is the internal configuration port, ports 1 to 8 are serial links and ports 9 and 10 are parallel FIFO ports. When the first byte of a packet arrives, the block reads it as the routing address. It turns that address into a one-hot request for a single output port and a priority bit. It also returns a flag that says whether the address byte is removed before forwarding. A packet that cannot be delivered is marked for discard instead.

Low addresses name a physical port directly. High addresses are logical. Each logical address reads its own entry in a routing table, and that entry lists a set of allowed output ports. The block sends the packet to a member of that set that is running and idle. If every running member is busy, the packet waits.

Two further rules apply. When returning to the arrival port is forbidden, a packet that resolves to its own input port is dropped and flagged, unless it is a configuration reply. When start-on-request is enabled, a packet aimed only at links that are not running does not drop: it asks those links to start and waits for them.

Top module: `pkt_route_decode`

## Requirements
- R1: Addresses 0 to 10 request exactly the port of that number (out_req bit n = port n). They carry priority 0 and set hdr_del.
- R2: Addresses 11 to 31 drop the packet. discard is set, addr_err pulses, and out_req stays 0.
- R3: Address A of 32 or more reads the 13-bit entry at route_tbl[(A-32)*13 +: 13]. In that entry, bit 0 is unused, bits 10:1 mark allowed ports 10..1, bit 11 is header delete and bit 12 is priority. hdr_del and prio take the entry's values.
- R4: Among the allowed ports that have port_ready=1 and port_busy=0, the lowest-numbered one is granted. out_req is never more than one-hot.
- R5: A table entry whose bits 10:1 are all zero drops the packet with an address error.
- R6: Suppose self_addr_en=0 and is_reply=0, and the chosen port equals in_port. Then the packet is dropped with an address error. If self_addr_en=1 or is_reply=1, it is granted.
- R7: Suppose no allowed port has port_ready=1 and start_on_req_en=0. Then the packet is dropped without an address error. discard and a nonzero out_req never occur together.
- R8: Suppose no allowed port has port_ready=1 and start_on_req_en=1. Then link_start_req marks the allowed ports that are not ready, and the packet waits. It is granted on the cycle after a member becomes ready and free, and link_start_req then returns to 0.
- R9: Suppose some allowed port is ready but all ready ones are busy. Then out_req and discard stay 0 and the port inputs are re-examined every cycle. The first port that becomes free is granted one cycle later.
- R10: Results appear on the clock edge that samples hdr_valid. They are held until the edge that samples eop_done, and all outputs then clear. hdr_valid is ignored while a packet is held or waiting. eop_done is ignored while waiting.
- R11: addr_err is high for exactly one cycle, always together with discard. discard stays high until eop_done.
- R12: After reset, out_req, prio, hdr_del, discard, addr_err and link_start_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header byte valid this cycle |
| hdr_byte | input | 8 | First byte of packet (routing address) |
| in_port | input | 4 | Number of the port the packet arrived on |
| is_reply | input | 1 | Packet is a configuration reply |
| eop_done | input | 1 | End marker of the current packet consumed |
| route_tbl | input | 2912 | 224 logical entries of 13 bits, entry k for address k+32 |
| port_ready | input | 11 | Per-port link running / ready |
| port_busy | input | 11 | Per-port busy with another packet |
| self_addr_en | input | 1 | Allow routing back to the arrival port |
| start_on_req_en | input | 1 | Start stopped links instead of dropping |
| out_req | output | 11 | One-hot granted output port |
| prio | output | 1 | Packet priority (1 = high) |
| hdr_del | output | 1 | Strip header byte |
| discard | output | 1 | Packet is to be dropped |
| addr_err | output | 1 | One-cycle address error strobe |
| link_start_req | output | 11 | Start requests for stopped links |

## Verification
The hardest situation to reach is a packet that is waiting on its port set and is then resolved by a change in the port flags rather than by a new header. The bench first marks every member of a group busy and checks the wait state. It then pulses eop_done, which must have no effect. Next it frees a single member and checks that the grant appears on the following edge and stays latched while the flags and header inputs are changed. A similar sequence uses a stopped link with start-on-request enabled, so the start request is seen before the link is brought up.

// File: rtl/pkt_route_pkg.sv
package pkt_route_pkg;
  localparam int NPORT_DEF    = 11;
  localparam int ADDR_W_DEF   = 8;
  localparam int LOG_BASE_DEF = 32;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_WAIT  = 2'd1,
    S_ROUTE = 2'd2,
    S_DROP  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/rd_rst_sync.sv
module rd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_n_s <= meta_q;
    end
  end
endmodule

// File: rtl/route_addr_decode.sv
module route_addr_decode #(
  parameter int NPORT    = 11,
  parameter int ADDR_W   = 8,
  parameter int LOG_BASE = 32,
  parameter int TBL_N    = (1 << ADDR_W) - LOG_BASE,
  parameter int ENT_W    = NPORT + 2,
  parameter int TBL_BITS = TBL_N * ENT_W
) (
  input  logic [ADDR_W-1:0]   hdr,
  input  logic [TBL_BITS-1:0] tbl,
  output logic [NPORT-1:0]    cand,
  output logic                prio,
  output logic                del
);
  localparam int DIRECT_MAX = NPORT - 1;
  localparam int BASE_W     = $clog2(TBL_BITS);

  logic [ADDR_W-1:0] idx;
  logic [BASE_W-1:0] base;
  logic [ENT_W-1:0]  ent;

  always_comb begin
    idx  = (hdr >= ADDR_W'(LOG_BASE)) ? hdr - ADDR_W'(LOG_BASE) : '0;
    base = BASE_W'(idx) * BASE_W'(ENT_W);
    ent  = tbl[base +: ENT_W];
    cand = '0;
    prio = 1'b0;
    del  = 1'b0;
    if (hdr <= ADDR_W'(DIRECT_MAX)) begin
      // direct path: one port, header stripped, low priority
      cand = NPORT'(1) << hdr;
      del  = 1'b1;
    end else if (hdr >= ADDR_W'(LOG_BASE)) begin
      // logical: bit 0 reserved, port bits above, then delete, then priority
      cand = {ent[NPORT-1:1], 1'b0};
      del  = ent[NPORT];
      prio = ent[NPORT+1];
    end
  end
endmodule

// File: rtl/route_port_pick.sv
module route_port_pick #(
  parameter int NPORT = 11,
  parameter int PW    = $clog2(NPORT)
) (
  input  logic [NPORT-1:0] cand,
  input  logic [NPORT-1:0] ready,
  input  logic [NPORT-1:0] busy,
  input  logic [PW-1:0]    in_port,
  input  logic             self_en,
  input  logic             reply,
  input  logic             sor_en,
  output logic [NPORT-1:0] grant,
  output logic             drop,
  output logic             err,
  output logic [NPORT-1:0] start
);
  logic [NPORT-1:0] avail, running, lowest, in_bit;
  logic             self_hit, none;

  always_comb begin
    running  = cand & ready;
    avail    = running & ~busy;
    lowest   = avail & (~avail + NPORT'(1));
    in_bit   = NPORT'(1) << in_port;
    none     = (cand == '0);
    self_hit = (lowest != '0) && (lowest == in_bit) && !self_en && !reply;
    grant    = self_hit ? '0 : lowest;
    err      = none || self_hit;
    drop     = err || ((running == '0) && !sor_en);
    start    = (!none && (running == '0) && sor_en) ? (cand & ~ready) : '0;
  end
endmodule

// File: rtl/pkt_route_decode.sv
module pkt_route_decode
  import pkt_route_pkg::*;
#(
  parameter int NPORT    = NPORT_DEF,
  parameter int ADDR_W   = ADDR_W_DEF,
  parameter int LOG_BASE = LOG_BASE_DEF,
  localparam int PW       = $clog2(NPORT),
  localparam int TBL_N    = (1 << ADDR_W) - LOG_BASE,
  localparam int ENT_W    = NPORT + 2,
  localparam int TBL_BITS = TBL_N * ENT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hdr_valid,
  input  logic [ADDR_W-1:0]   hdr_byte,
  input  logic [PW-1:0]       in_port,
  input  logic                is_reply,
  input  logic                eop_done,
  input  logic [TBL_BITS-1:0] route_tbl,
  input  logic [NPORT-1:0]    port_ready,
  input  logic [NPORT-1:0]    port_busy,
  input  logic                self_addr_en,
  input  logic                start_on_req_en,
  output logic [NPORT-1:0]    out_req,
  output logic                prio,
  output logic                hdr_del,
  output logic                discard,
  output logic                addr_err,
  output logic [NPORT-1:0]    link_start_req
);
  logic rst_n_s;

  rd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  logic [NPORT-1:0] dec_cand;
  logic             dec_prio, dec_del;

  route_addr_decode #(
    .NPORT(NPORT), .ADDR_W(ADDR_W), .LOG_BASE(LOG_BASE),
    .TBL_N(TBL_N), .ENT_W(ENT_W), .TBL_BITS(TBL_BITS)
  ) u_dec (
    .hdr(hdr_byte), .tbl(route_tbl),
    .cand(dec_cand), .prio(dec_prio), .del(dec_del)
  );

  rd_state_e        st_q, st_d;
  logic [NPORT-1:0] cand_q, cand_d, grant_q, grant_d, start_q, start_d;
  logic [PW-1:0]    inp_q, inp_d;
  logic             rep_q, rep_d, prio_q, prio_d, del_q, del_d, err_q, err_d;
  logic             ctx_en;

  logic [NPORT-1:0] sel_cand, pk_grant, pk_start;
  logic [PW-1:0]    sel_inp;
  logic             sel_rep, pk_drop, pk_err;

  // in idle the fresh decode is resolved, while waiting the stored set
  always_comb begin
    sel_cand = (st_q == S_IDLE) ? dec_cand : cand_q;
    sel_inp  = (st_q == S_IDLE) ? in_port  : inp_q;
    sel_rep  = (st_q == S_IDLE) ? is_reply : rep_q;
  end

  route_port_pick #(.NPORT(NPORT), .PW(PW)) u_pick (
    .cand(sel_cand), .ready(port_ready), .busy(port_busy),
    .in_port(sel_inp), .self_en(self_addr_en), .reply(sel_rep),
    .sor_en(start_on_req_en),
    .grant(pk_grant), .drop(pk_drop), .err(pk_err), .start(pk_start)
  );

  always_comb begin
    st_d    = st_q;
    cand_d  = cand_q;
    inp_d   = inp_q;
    rep_d   = rep_q;
    prio_d  = prio_q;
    del_d   = del_q;
    grant_d = grant_q;
    err_d   = 1'b0;
    start_d = '0;
    ctx_en  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (hdr_valid) begin
          ctx_en = 1'b1;
          cand_d = dec_cand;
          inp_d  = in_port;
          rep_d  = is_reply;
          prio_d = dec_prio;
          del_d  = dec_del;
        end
      end
      S_WAIT: ctx_en = 1'b1;
      S_ROUTE, S_DROP: begin
        if (eop_done) begin
          ctx_en  = 1'b1;
          st_d    = S_IDLE;
          grant_d = '0;
          prio_d  = 1'b0;
          del_d   = 1'b0;
        end
      end
      default: st_d = S_IDLE;
    endcase
    if ((st_q == S_IDLE && hdr_valid) || st_q == S_WAIT) begin
      if (pk_drop) begin
        st_d  = S_DROP;
        err_d = pk_err;
      end else if (pk_grant != '0) begin
        st_d    = S_ROUTE;
        grant_d = pk_grant;
      end else begin
        st_d    = S_WAIT;
        start_d = pk_start;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q    <= S_IDLE;
      err_q   <= 1'b0;
      start_q <= '0;
    end else begin
      st_q    <= st_d;
      err_q   <= err_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cand_q  <= '0;
      inp_q   <= '0;
      rep_q   <= 1'b0;
      prio_q  <= 1'b0;
      del_q   <= 1'b0;
      grant_q <= '0;
    end else if (ctx_en) begin
      cand_q  <= cand_d;
      inp_q   <= inp_d;
      rep_q   <= rep_d;
      prio_q  <= prio_d;
      del_q   <= del_d;
      grant_q <= grant_d;
    end
  end

  assign out_req        = grant_q;
  assign prio           = prio_q;
  assign hdr_del        = del_q;
  assign discard        = (st_q == S_DROP);
  assign addr_err       = err_q;
  assign link_start_req = start_q;

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(out_req));
  assert_hold_grant_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((out_req != '0) && !eop_done) |=> $stable(out_req));
  assert_drop_excl_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(discard && (out_req != '0)));
  assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    addr_err |=> !addr_err);
  assert_err_with_drop_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    addr_err |-> discard);
  assert_start_waiting_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (link_start_req != '0) |-> ((out_req == '0) && !discard));
endmodule

// File: tb/sim_pkt_route_decode.sv
module sim_pkt_route_decode;
  localparam int NP = 11;
  localparam int TB = 224 * 13;
  localparam logic [10:0] ALL = 11'h7FF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hdr_valid = 1'b0, is_reply = 1'b0, eop_done = 1'b0;
  logic [7:0] hdr_byte = '0;
  logic [3:0] in_port = '0;
  logic [TB-1:0] route_tbl = '0;
  logic [NP-1:0] port_ready = ALL, port_busy = '0;
  logic self_addr_en = 1'b0, start_on_req_en = 1'b0;
  logic [NP-1:0] out_req, link_start_req;
  logic prio, hdr_del, discard, addr_err;

  int vectors = 0, miscompares = 0;

  always #2.5 clk = ~clk;

  pkt_route_decode u0 (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_byte(hdr_byte),
    .in_port(in_port), .is_reply(is_reply), .eop_done(eop_done),
    .route_tbl(route_tbl), .port_ready(port_ready), .port_busy(port_busy),
    .self_addr_en(self_addr_en), .start_on_req_en(start_on_req_en),
    .out_req(out_req), .prio(prio), .hdr_del(hdr_del), .discard(discard),
    .addr_err(addr_err), .link_start_req(link_start_req)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [3:0]  ip;
    logic [10:0] rdy;
    logic [10:0] bsy;
    logic        se;
    logic        sor;
    logic        rep;
    logic [10:0] xreq;
    logic        xpri;
    logic        xdel;
    logic        xdis;
    logic        xerr;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t VEC [0:17] = '{
    '{8'd3,   4'd1, ALL,     11'h000, 1'b0, 1'b0, 1'b0, 11'h008, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1}, // R1
    '{8'd0,   4'd2, ALL,     11'h000, 1'b0, 1'b0, 1'b0, 11'h001, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1}, // R1
    '{8'd10,  4'd1, ALL,     11'h000, 1'b0, 1'b0, 1'b0, 11'h400, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1}, // R1
    '{8'd20,  4'd1, ALL,     11'h000, 1'b0, 1'b0, 1'b0, 11'h000, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2}, // R2
    '{8'd11,  4'd1, ALL,     11'h000, 1'b0, 1'b0, 1'b0, 11'h000, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2}, // R2
    '{8'd31,  4'd1, ALL,     11'h000, 1'b0, 1'b0, 1'b0, 11'h000, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2}, // R2
    '{8'd40,  4'd1, ALL,     11'h010, 1'b0, 1'b0, 1'b0, 11'h020, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4}, // R4
    '{8'd40,  4'd1, ALL,     11'h030, 1'b0, 1'b0, 1'b0, 11'h040, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4}, // R4
    '{8'd40,  4'd1, 11'h7EF, 11'h000, 1'b0, 1'b0, 1'b0, 11'h020, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4}, // R4
    '{8'd50,  4'd1, ALL,     11'h000, 1'b0, 1'b0, 1'b0, 11'h000, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5}, // R5
    '{8'd255, 4'd1, ALL,     11'h000, 1'b0, 1'b0, 1'b0, 11'h200, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3}, // R3
    '{8'd5,   4'd5, ALL,     11'h000, 1'b0, 1'b0, 1'b0, 11'h000, 1'b0, 1'b1, 1'b1, 1'b1, 4'd6}, // R6
    '{8'd5,   4'd5, ALL,     11'h000, 1'b1, 1'b0, 1'b0, 11'h020, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6}, // R6
    '{8'd5,   4'd5, ALL,     11'h000, 1'b0, 1'b0, 1'b1, 11'h020, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6}, // R6
    '{8'd7,   4'd1, 11'h77F, 11'h000, 1'b0, 1'b0, 1'b0, 11'h000, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7}, // R7
    '{8'd32,  4'd2, ALL,     11'h000, 1'b0, 1'b0, 1'b0, 11'h000, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6}, // R6
    '{8'd40,  4'd1, 11'h78F, 11'h000, 1'b0, 1'b0, 1'b0, 11'h000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7}, // R7
    '{8'd32,  4'd3, ALL,     11'h000, 1'b0, 1'b0, 1'b0, 11'h004, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4}  // R4
  };

  function automatic logic [12:0] mk_ent(input logic p, input logic d, input logic [10:0] m);
    return {p, d, m[10:1], 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_pkt();
    eop_done = 1'b1;
    @(negedge clk);
    eop_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    route_tbl[(40-32)*13 +: 13]  = mk_ent(1'b1, 1'b0, 11'h070);
    route_tbl[(255-32)*13 +: 13] = mk_ent(1'b0, 1'b1, 11'h200);
    route_tbl[(32-32)*13 +: 13]  = mk_ent(1'b0, 1'b0, 11'h00C);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 reset", {out_req, prio, hdr_del, discard, addr_err, link_start_req},
        {11'h0, 4'h0, 11'h0});

    // table walk: R1..R7
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      hdr_byte = VEC[i].a; in_port = VEC[i].ip; port_ready = VEC[i].rdy;
      port_busy = VEC[i].bsy; self_addr_en = VEC[i].se;
      start_on_req_en = VEC[i].sor; is_reply = VEC[i].rep; hdr_valid = 1'b1;
      @(negedge clk);
      hdr_valid = 1'b0;
      chk($sformatf("R%0d vec%0d", VEC[i].rq, i),
          {out_req, prio, hdr_del, discard, addr_err, link_start_req},
          {VEC[i].xreq, VEC[i].xpri, VEC[i].xdel, VEC[i].xdis, VEC[i].xerr, 11'h0});
      finish_pkt();
    end
    self_addr_en = 1'b0; is_reply = 1'b0; start_on_req_en = 1'b0;
    port_ready = ALL; port_busy = '0;

    // R9 wait on busy group, eop_done ignored while waiting (R10)
    @(negedge clk);
    hdr_byte = 8'd40; in_port = 4'd1; port_busy = 11'h070; hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk("R9 waiting", {out_req, discard}, {11'h0, 1'b0});
    eop_done = 1'b1;
    @(negedge clk);
    eop_done = 1'b0;
    chk("R10 eop ignored while waiting", {out_req, discard}, {11'h0, 1'b0});
    port_busy = 11'h050;
    @(negedge clk);
    chk("R9 grant when freed", {out_req, prio}, {11'h020, 1'b1});
    // R10 held: new header and flag changes ignored
    port_busy = 11'h000; hdr_byte = 8'd3; hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk("R10 held", {out_req, prio}, {11'h020, 1'b1});
    finish_pkt();
    chk("R10 cleared", {out_req, prio, hdr_del, discard}, {11'h0, 3'b0});

    // R8 start on request
    port_ready = ALL & ~11'h080; start_on_req_en = 1'b1;
    hdr_byte = 8'd7; in_port = 4'd1; hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk("R8 start request", {link_start_req, out_req, discard}, {11'h080, 11'h0, 1'b0});
    port_ready = ALL;
    @(negedge clk);
    chk("R8 grant after start", {out_req, link_start_req}, {11'h080, 11'h0});
    finish_pkt();
    start_on_req_en = 1'b0;

    // R11 strobe length
    hdr_byte = 8'd20; hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk("R11 err first cycle", {discard, addr_err}, 2'b11);
    @(negedge clk);
    chk("R11 err one cycle", {discard, addr_err}, 2'b10);
    finish_pkt();
    chk("R11 discard cleared", {discard, addr_err}, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule